// File: doc/BRIEF.md
# Privilege-Masked Flags Pop Unit

This unit holds a processor's 32-bit flags register and merges a value taken off the stack into it. Each bit group is guarded by a write mask built from the operand size, the current privilege level, the privilege field already held in the register, and the execution mode. When the caller lacks the privilege for a guarded bit, that bit keeps its old value while the other bits still load, and no exception is raised.

The same unit also grants the matching flags push. It returns the register image to be stored, so the push is refused under exactly the same rule that refuses a pop. In virtual-8086 mode, a pop or push attempted while the I/O privilege field is below 3 produces a general-protection fault strobe and leaves the register untouched. The I/O privilege field (bits 13:12) is read from the register that this unit holds.

Every result appears in the cycle after the request strobe. The stack memory access itself is done elsewhere.

Top module: `flagpop_unit`

## Requirements
- R1: After reset the flags register reads 32'h0000_0002, and `flags_we`, `gp_fault` and `push_grant` are low.
- R2: A pop request sampled on a clock edge drives `flags_we` high for exactly the next cycle, with the new flags value already visible in that cycle. Without a request the register holds its value.
- R3: When `wide_op` is 0 the pop writes only bits 15:0 and bits 31:16 keep their value. When `wide_op` is 1 every bit may change, subject to the masks in R4 to R6.
- R4: Bit 16 and bit 17 are never changed by a pop.
- R5: The I/O privilege field, bits 13:12, is written only when the effective privilege level is 0.
- R6: The interrupt-enable bit, bit 9, is written only when the effective privilege level is numerically less than or equal to the I/O privilege field held before the pop.
- R7: A pop that lacks privilege for bits 13:12 or bit 9 raises no fault. Those bits keep their old values, and all other writable bits load from `pop_data`.
- R8: While `rmode` is high the effective privilege level is 0, whatever `priv_lvl` says.
- R9: While `vmode` is high (and `rmode` is low), a pop made with the held I/O privilege field below 3 pulses `gp_fault` in the next cycle, keeps `flags_we` low and leaves the register unchanged. With the field equal to 3 the pop proceeds normally.
- R10: A push request pulses `push_grant` in the next cycle. `push_data` then holds the flags value, with bits 31:16 zeroed when `wide_op` is 0. Under the R9 condition the push instead pulses `gp_fault` and `push_grant` stays low.
- R11: The register always reads bit 1 as 1 and bits 3, 5 and 15 as 0, whatever value was popped.
- R12: When pop and push are requested in the same cycle, the pop is carried out and the push is dropped. No grant is given for it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pop_vld | input | 1 | Pop request strobe |
| push_vld | input | 1 | Push request strobe |
| wide_op | input | 1 | 1 = 32-bit operand, 0 = 16-bit operand |
| pop_data | input | 32 | Value read from the stack |
| priv_lvl | input | 2 | Current privilege level |
| rmode | input | 1 | Real-address mode indicator |
| vmode | input | 1 | Virtual-8086 mode indicator |
| flags | output | 32 | Flags register |
| flags_we | output | 1 | Flags written this cycle |
| gp_fault | output | 1 | General-protection fault strobe |
| push_grant | output | 1 | Push allowed, `push_data` valid |
| push_data | output | 32 | Flags image to store on the stack |

## Verification
The hardest case to reach is virtual-8086 operation with the privilege field at 3. The field cannot be set directly, so the stimulus first pops at level 0 to raise it, and only then enables `vmode` to show that the interrupt bit moves at level 3 while the field stays fixed. After that, a privileged pop returns the field to 0, so that the same `vmode` requests now fault for both pop and push. Bits 17:16 cannot be set from the ports at all, so they are exercised by popping all-ones and checking that they stay clear.

// File: rtl/flagpop_pkg.sv
package flagpop_pkg;
    // Bit positions the surrounding core decodes
    localparam int unsigned B_IF      = 9;
    localparam int unsigned B_PL_LO   = 12;
    localparam int unsigned B_PL_HI   = 13;
    localparam int unsigned B_VM      = 16;
    localparam int unsigned B_RF      = 17;
    // Reserved positions
    localparam int unsigned B_ONE     = 1;
    localparam int unsigned B_Z0      = 3;
    localparam int unsigned B_Z1      = 5;
    localparam int unsigned B_Z2      = 15;
    localparam logic [1:0]  PL_TOP    = 2'd3;
endpackage

// File: rtl/flagpop_mask.sv
module flagpop_mask
    import flagpop_pkg::*;
#(
    parameter int unsigned FLAG_W = 32
) (
    input  logic              wide_op,
    input  logic [1:0]        eff_pl,
    input  logic [1:0]        io_pl,
    output logic [FLAG_W-1:0] wmask
);
    localparam int unsigned HALF_W = FLAG_W / 2;

    always_comb begin
        wmask = '0;
        if (wide_op) begin
            wmask = '1;
        end else begin
            wmask[HALF_W-1:0] = '1;
        end
        wmask[B_VM] = 1'b0;
        wmask[B_RF] = 1'b0;
        if (eff_pl != 2'd0) begin
            wmask[B_PL_HI:B_PL_LO] = 2'b00;
        end
        if (eff_pl > io_pl) begin
            wmask[B_IF] = 1'b0;
        end
    end
endmodule

// File: rtl/flagpop_merge.sv
module flagpop_merge
    import flagpop_pkg::*;
#(
    parameter int unsigned FLAG_W = 32
) (
    input  logic [FLAG_W-1:0] old_val,
    input  logic [FLAG_W-1:0] new_val,
    input  logic [FLAG_W-1:0] wmask,
    output logic [FLAG_W-1:0] merged
);
    always_comb begin
        merged = (old_val & ~wmask) | (new_val & wmask);
        merged[B_ONE] = 1'b1;
        merged[B_Z0]  = 1'b0;
        merged[B_Z1]  = 1'b0;
        merged[B_Z2]  = 1'b0;
    end
endmodule

// File: rtl/flagpop_gate.sv
module flagpop_gate
    import flagpop_pkg::*;
(
    input  logic       pop_vld,
    input  logic       push_vld,
    input  logic       rmode,
    input  logic       vmode,
    input  logic [1:0] io_pl,
    output logic       do_pop,
    output logic       do_push,
    output logic       trap
);
    logic v86_block;

    always_comb begin
        v86_block = vmode && !rmode && (io_pl != PL_TOP);
        do_pop    = pop_vld && !v86_block;
        do_push   = push_vld && !pop_vld && !v86_block;
        trap      = (pop_vld || push_vld) && v86_block;
    end
endmodule

// File: rtl/flagpop_unit.sv
module flagpop_unit
    import flagpop_pkg::*;
#(
    parameter int unsigned FLAG_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pop_vld,
    input  logic              push_vld,
    input  logic              wide_op,
    input  logic [FLAG_W-1:0] pop_data,
    input  logic [1:0]        priv_lvl,
    input  logic              rmode,
    input  logic              vmode,
    output logic [FLAG_W-1:0] flags,
    output logic              flags_we,
    output logic              gp_fault,
    output logic              push_grant,
    output logic [FLAG_W-1:0] push_data
);
    localparam int unsigned HALF_W = FLAG_W / 2;
    localparam logic [FLAG_W-1:0] RST_FLAGS = FLAG_W'(1) << B_ONE;

    typedef struct packed {
        logic [FLAG_W-1:0] fl;
        logic              we;
        logic              flt;
        logic              gnt;
        logic [FLAG_W-1:0] img;
    } st_t;

    st_t st_d, st_q;

    logic [1:0]        eff_pl;
    logic [1:0]        io_pl;
    logic [FLAG_W-1:0] wmask;
    logic [FLAG_W-1:0] merged;
    logic              do_pop, do_push, trap;

    assign io_pl  = st_q.fl[B_PL_HI:B_PL_LO];
    assign eff_pl = rmode ? 2'd0 : priv_lvl;

    flagpop_mask #(.FLAG_W(FLAG_W)) u_mask (
        .wide_op (wide_op),
        .eff_pl  (eff_pl),
        .io_pl   (io_pl),
        .wmask   (wmask)
    );

    flagpop_merge #(.FLAG_W(FLAG_W)) u_merge (
        .old_val (st_q.fl),
        .new_val (pop_data),
        .wmask   (wmask),
        .merged  (merged)
    );

    flagpop_gate u_gate (
        .pop_vld  (pop_vld),
        .push_vld (push_vld),
        .rmode    (rmode),
        .vmode    (vmode),
        .io_pl    (io_pl),
        .do_pop   (do_pop),
        .do_push  (do_push),
        .trap     (trap)
    );

    always_comb begin
        st_d     = st_q;
        st_d.we  = do_pop;
        st_d.flt = trap;
        st_d.gnt = do_push;
        if (do_pop) begin
            st_d.fl = merged;
        end
        if (do_push) begin
            st_d.img = st_q.fl;
            if (!wide_op) begin
                st_d.img[FLAG_W-1:HALF_W] = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.fl  <= RST_FLAGS;
            st_q.we  <= 1'b0;
            st_q.flt <= 1'b0;
            st_q.gnt <= 1'b0;
            st_q.img <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags      = st_q.fl;
    assign flags_we   = st_q.we;
    assign gp_fault   = st_q.flt;
    assign push_grant = st_q.gnt;
    assign push_data  = st_q.img;
endmodule

// File: rtl/flagpop_chk.sv
module flagpop_chk #(
    parameter int unsigned FLAG_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pop_vld,
    input logic              push_vld,
    input logic              wide_op,
    input logic [1:0]        priv_lvl,
    input logic              rmode,
    input logic [FLAG_W-1:0] flags,
    input logic              flags_we,
    input logic              gp_fault,
    input logic              push_grant
);
    p_we_timing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        flags_we |-> $past(pop_vld));

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !flags_we |-> flags == $past(flags));

    p_upper_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_we && !$past(wide_op)) |-> flags[31:16] == $past(flags[31:16]));

    p_vmrf_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        flags_we |-> flags[17:16] == $past(flags[17:16]));

    p_pl_guard_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_we && $past(priv_lvl) != 2'd0 && !$past(rmode))
            |-> flags[13:12] == $past(flags[13:12]));

    p_if_guard_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_we && !$past(rmode) && ($past(priv_lvl) > $past(flags[13:12])))
            |-> flags[9] == $past(flags[9]));

    p_fault_nowrite_r9: assert property (@(posedge clk) disable iff (!rst_n)
        gp_fault |-> (!flags_we && flags == $past(flags)));

    p_grant_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
        push_grant |-> ($past(push_vld) && !$past(pop_vld)));

    p_rsvd_bits_r11: assert property (@(posedge clk) disable iff (!rst_n)
        flags_we |-> (flags[1] && !flags[3] && !flags[5] && !flags[15]));

    p_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flags_we, gp_fault, push_grant}));
endmodule

bind flagpop_unit flagpop_chk #(.FLAG_W(FLAG_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pop_vld    (pop_vld),
    .push_vld   (push_vld),
    .wide_op    (wide_op),
    .priv_lvl   (priv_lvl),
    .rmode      (rmode),
    .flags      (flags),
    .flags_we   (flags_we),
    .gp_fault   (gp_fault),
    .push_grant (push_grant)
);

// File: tb/flagpop_unit_tb.sv
`timescale 1ns/1ps
module flagpop_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pop_vld = 1'b0, push_vld = 1'b0, wide_op = 1'b0;
    logic [31:0] pop_data = '0;
    logic [1:0]  priv_lvl = '0;
    logic        rmode = 1'b0, vmode = 1'b0;
    logic [31:0] flags, push_data;
    logic        flags_we, gp_fault, push_grant;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    flagpop_unit u_dut (
        .clk(clk), .rst_n(rst_n), .pop_vld(pop_vld), .push_vld(push_vld),
        .wide_op(wide_op), .pop_data(pop_data), .priv_lvl(priv_lvl),
        .rmode(rmode), .vmode(vmode), .flags(flags), .flags_we(flags_we),
        .gp_fault(gp_fault), .push_grant(push_grant), .push_data(push_data)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // Drive a request for one cycle, then stop at the negedge after the edge
    task automatic issue(input logic pop, input logic push, input logic [31:0] d,
                         input logic w, input logic [1:0] pl, input logic rm, input logic vm);
        @(negedge clk);
        pop_vld = pop; push_vld = push; pop_data = d; wide_op = w;
        priv_lvl = pl; rmode = rm; vmode = vm;
        @(negedge clk);
        pop_vld = 1'b0; push_vld = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 flags", flags, 32'h0000_0002);
        check("R1 we", {31'b0, flags_we}, 32'd0);
        check("R1 fault", {31'b0, gp_fault}, 32'd0);
        check("R1 grant", {31'b0, push_grant}, 32'd0);
    endtask

    task automatic t_wide_all_ones;
        issue(1, 0, 32'hFFFF_FFFF, 1, 2'd0, 0, 0);
        check("R2 we pulse", {31'b0, flags_we}, 32'd1);
        check("R4 R11 wide pop", flags, 32'hFFFC_7FD7);
        @(negedge clk);
        check("R2 we drops", {31'b0, flags_we}, 32'd0);
        check("R2 hold", flags, 32'hFFFC_7FD7);
    endtask

    task automatic t_narrow;
        issue(1, 0, 32'h0000_0000, 0, 2'd0, 0, 0);
        check("R3 narrow pop", flags, 32'hFFFC_0002);
    endtask

    task automatic t_unpriv;
        issue(1, 0, 32'h0000_3201, 1, 2'd3, 0, 0);
        check("R7 no fault", {31'b0, gp_fault}, 32'd0);
        check("R5 R6 R7 masked", flags, 32'h0000_0003);
    endtask

    task automatic t_if_rules;
        issue(1, 0, 32'h0000_1000, 1, 2'd0, 0, 0);
        check("R5 pl write", flags, 32'h0000_1002);
        issue(1, 0, 32'h0000_0200, 1, 2'd1, 0, 0);
        check("R6 if allowed", flags, 32'h0000_1202);
        issue(1, 0, 32'h0000_0000, 1, 2'd2, 0, 0);
        check("R6 if kept", flags, 32'h0000_1202);
    endtask

    task automatic t_real;
        issue(1, 0, 32'h0000_3000, 1, 2'd3, 1, 0);
        check("R8 real mode", flags, 32'h0000_3002);
    endtask

    task automatic t_v86_ok;
        issue(1, 0, 32'h0000_0201, 1, 2'd3, 0, 1);
        check("R9 v86 pl3 no fault", {31'b0, gp_fault}, 32'd0);
        check("R9 v86 pl3 pop", flags, 32'h0000_3203);
        issue(0, 1, 32'h0, 1, 2'd3, 0, 1);
        check("R10 v86 grant", {31'b0, push_grant}, 32'd1);
        check("R10 v86 image", push_data, 32'h0000_3203);
    endtask

    task automatic t_v86_fault;
        issue(1, 0, 32'h0000_0000, 1, 2'd0, 0, 0);
        check("R5 pl lowered", flags, 32'h0000_0002);
        issue(1, 0, 32'hFFFF_FFFF, 1, 2'd3, 0, 1);
        check("R9 fault", {31'b0, gp_fault}, 32'd1);
        check("R9 no we", {31'b0, flags_we}, 32'd0);
        check("R9 unchanged", flags, 32'h0000_0002);
        issue(0, 1, 32'h0, 1, 2'd3, 0, 1);
        check("R10 push fault", {31'b0, gp_fault}, 32'd1);
        check("R10 no grant", {31'b0, push_grant}, 32'd0);
    endtask

    task automatic t_push_sizes;
        issue(1, 0, 32'h0004_0001, 1, 2'd0, 0, 0);
        check("R3 upper bit", flags, 32'h0004_0003);
        issue(0, 1, 32'h0, 0, 2'd0, 0, 0);
        check("R10 narrow grant", {31'b0, push_grant}, 32'd1);
        check("R10 narrow image", push_data, 32'h0000_0003);
        issue(0, 1, 32'h0, 1, 2'd0, 0, 0);
        check("R10 wide image", push_data, 32'h0004_0003);
    endtask

    task automatic t_both;
        issue(1, 1, 32'h0000_0000, 1, 2'd0, 0, 0);
        check("R12 pop done", {31'b0, flags_we}, 32'd1);
        check("R12 push dropped", {31'b0, push_grant}, 32'd0);
        check("R12 flags", flags, 32'h0000_0002);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_wide_all_ones();
        t_narrow();
        t_unpriv();
        t_if_rules();
        t_real();
        t_v86_ok();
        t_v86_fault();
        t_push_sizes();
        t_both();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: actual=running expected=done");
            end
        join_any
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule